// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside the fetch unit and remembers the first instructions found at branch targets that were recently taken. Whenever fetch is redirected to a target address, the address is presented as a lookup. On a hit, the stored instructions are handed to the instruction queue one cycle later. Fetch therefore does not sit idle while the instruction cache access for the target completes.

The store holds 16 sets of 4 ways. The set is chosen by the word address bits just above the byte offset, and the tag is every address bit above the set index. Each entry holds one or two instruction words. Only one word is kept, and only one is returned, when the target is the last word of an 8-word instruction cache block. After a miss, fetch returns the instructions at the target through a single-cycle fill port, and the block writes them into a way of the target's set. That way is the first free way, or else the way chosen by a tree pseudo-LRU. A global invalidate input empties the whole store.

Top module: `btic_top`

## Requirements
- R1: After reset every entry is empty: hitValid, hitCount, hitInstr0 and hitInstr1 are all zero, and every lookup misses until a fill has been written.
- R2: A lookup is presented in cycle N with lookupValid high. If it matches a valid entry, hitValid is 1 after the clock edge that ends cycle N, together with the stored words. On a miss, or when lookupValid is low, hitValid, hitCount and both words are 0.
- R3: The word offset is address bits [4:2]. If the offset is not 7, a hit gives hitCount = 2 with both words. If the offset is 7 (the last word of a block), a hit gives hitCount = 1, the word in hitInstr0, and zero in hitInstr1.
- R4: A fill with fillValid high writes the entry at the clock edge. The set comes from address bits [5:2] and the tag from bits [31:6]. Address bits [1:0] take no part in fills or lookups.
- R5: A fill whose address is already held overwrites that same way with the new words. No second copy is made, and the other ways of the set are kept.
- R6: A fill of a new address takes the lowest-numbered invalid way of its set. If the set is full, the fill takes the way named by a 3-bit tree pseudo-LRU, which every hit and every fill steers away from the way it used. Example: fill A, B, C and D into an empty set, then hit A. The next new fill then evicts C.
- R7: If a lookup and a fill address the same set in the same cycle, the fill is written and the lookup reports a miss.
- R8: A lookup and a fill to different sets in the same cycle both take effect.
- R9: invalidate empties every entry at the clock edge. A lookup in that same cycle misses, and a fill in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| invalidate | input | 1 | Empty the whole store |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | 32 | Branch target address to search |
| fillValid | input | 1 | Fill request |
| fillAddr | input | 32 | Target address of the fill |
| fillInstr0 | input | 32 | Instruction at the target |
| fillInstr1 | input | 32 | Instruction after the target |
| hitValid | output | 1 | Registered hit flag |
| hitCount | output | 2 | Words delivered: 0, 1 or 2 |
| hitInstr0 | output | 32 | First target instruction |
| hitInstr1 | output | 32 | Second target instruction, zero if absent |

## Verification
A lookup's result is due exactly one clock edge after the cycle in which it is presented. A fill, an invalidate and a pseudo-LRU update take effect at that same edge, so the earliest lookup that can observe them is the one presented in the following cycle. Every scenario task drives its inputs on a falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. Same-cycle conflicts are checked by driving a fill, or an invalidate, together with a lookup in one cycle, and then repeating the lookup alone in the next cycle.

// File: rtl/btic_pkg.sv
package btic_pkg;
  localparam int BT_WAYS = 4;
  localparam int BT_LVL  = $clog2(BT_WAYS);

  typedef logic [BT_WAYS-1:0] wayVec_t;
  typedef logic [BT_LVL-1:0]  wayIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    clearAll;
    logic    fillWr;
    wayVec_t fillWay;
    logic    lkHit;
    wayVec_t lkWay;
  } btStrobe_t;

  function automatic wayIdx_t ohToIdx(wayVec_t oh);
    wayIdx_t r = '0;
    for (int i = 0; i < BT_WAYS; i++)
      if (oh[i]) r = wayIdx_t'(i);
    return r;
  endfunction

  // tree bits live at heap nodes 1..BT_WAYS-1; a bit holds the side of the victim
  function automatic wayIdx_t plruPick(wayVec_t b);
    int node = 1;
    for (int l = 0; l < BT_LVL; l++)
      node = node * 2 + int'(b[node]);
    return wayIdx_t'(node - BT_WAYS);
  endfunction

  function automatic wayVec_t plruTouch(wayVec_t b, wayIdx_t w);
    wayVec_t r = b;
    for (int l = 0; l < BT_LVL; l++) begin
      int node = (BT_WAYS + int'(w)) >> (BT_LVL - l);
      r[node] = ~w[BT_LVL-1-l];
    end
    return r;
  endfunction
endpackage

// File: rtl/btic_dp.sv
module btic_dp
  import btic_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_W     = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [INSTR_W-1:0] fillInstr0,
  input  logic [INSTR_W-1:0] fillInstr1,
  input  btStrobe_t          strobe,
  output wayVec_t            lkMatch,
  output wayVec_t            fillMatch,
  output wayVec_t            fillValidRow,
  output wayVec_t            fillPlru,
  output logic               sameSet,
  output logic               hitValid,
  output logic [1:0]         hitCount,
  output logic [INSTR_W-1:0] hitInstr0,
  output logic [INSTR_W-1:0] hitInstr1
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(BLOCK_WORDS);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [TAG_W-1:0]   tagMem [SETS][BT_WAYS];
  logic [INSTR_W-1:0] i0Mem  [SETS][BT_WAYS];
  logic [INSTR_W-1:0] i1Mem  [SETS][BT_WAYS];
  logic               twoMem [SETS][BT_WAYS];
  wayVec_t            validMem [SETS];
  wayVec_t            plruMem  [SETS];

  logic [IDX_W-1:0] lkSet, fillSet;
  logic [TAG_W-1:0] lkTag, fillTag;
  logic             fillTwo, lkLastWord;
  wayIdx_t          fillIdx, hitIdx;

  assign lkSet      = lookupAddr[2 +: IDX_W];
  assign fillSet    = fillAddr[2 +: IDX_W];
  assign lkTag      = lookupAddr[ADDR_W-1 -: TAG_W];
  assign fillTag    = fillAddr[ADDR_W-1 -: TAG_W];
  assign fillTwo    = (fillAddr[2 +: OFF_W] != '1);
  assign lkLastWord = (lookupAddr[2 +: OFF_W] == '1);
  assign sameSet    = (lkSet == fillSet);
  assign fillIdx    = ohToIdx(strobe.fillWay);
  assign hitIdx     = ohToIdx(strobe.lkWay);

  assign fillValidRow = validMem[fillSet];
  assign fillPlru     = plruMem[fillSet];

  for (genvar w = 0; w < BT_WAYS; w++) begin : g_cmp
    assign lkMatch[w]   = validMem[lkSet][w]   && (tagMem[lkSet][w]   == lkTag);
    assign fillMatch[w] = validMem[fillSet][w] && (tagMem[fillSet][w] == fillTag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || strobe.clearAll) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        plruMem[s]  <= '0;
      end
    end else begin
      if (strobe.fillWr) begin
        validMem[fillSet][fillIdx] <= 1'b1;
        plruMem[fillSet]           <= plruTouch(plruMem[fillSet], fillIdx);
      end
      if (strobe.lkHit)
        plruMem[lkSet] <= plruTouch(plruMem[lkSet], hitIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWr) begin
      tagMem[fillSet][fillIdx] <= fillTag;
      i0Mem[fillSet][fillIdx]  <= fillInstr0;
      i1Mem[fillSet][fillIdx]  <= fillTwo ? fillInstr1 : '0;
      twoMem[fillSet][fillIdx] <= fillTwo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid  <= 1'b0;
      hitCount  <= 2'd0;
      hitInstr0 <= '0;
      hitInstr1 <= '0;
    end else if (strobe.lkHit) begin
      hitValid  <= 1'b1;
      hitCount  <= twoMem[lkSet][hitIdx] ? 2'd2 : 2'd1;
      hitInstr0 <= i0Mem[lkSet][hitIdx];
      hitInstr1 <= twoMem[lkSet][hitIdx] ? i1Mem[lkSet][hitIdx] : '0;
    end else begin
      hitValid  <= 1'b0;
      hitCount  <= 2'd0;
      hitInstr0 <= '0;
      hitInstr1 <= '0;
    end
  end

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitCount == 2'd1 || hitCount == 2'd2));
  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitCount == 2'd0 && hitInstr0 == '0 && hitInstr1 == '0));
  // R3
  last_word_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lkHit && lkLastWord) |=> (hitCount == 2'd1 && hitInstr1 == '0));
  // R3
  mid_word_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lkHit && !lkLastWord) |=> (hitCount == 2'd2));
endmodule

// File: rtl/btic_ctrl.sv
module btic_ctrl
  import btic_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      invalidate,
  input  logic      lookupValid,
  input  logic      fillValid,
  input  logic      sameSet,
  input  wayVec_t   lkMatch,
  input  wayVec_t   fillMatch,
  input  wayVec_t   fillValidRow,
  input  wayVec_t   fillPlru,
  output btStrobe_t strobe
);
  wayIdx_t freeIdx, victimIdx;
  logic    anyFree;
  wayVec_t victimOh;

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < BT_WAYS; i++) begin
      if (!anyFree && !fillValidRow[i]) begin
        anyFree = 1'b1;
        freeIdx = wayIdx_t'(i);
      end
    end
  end

  assign victimIdx = anyFree ? freeIdx : plruPick(fillPlru);

  always_comb begin
    victimOh = '0;
    victimOh[victimIdx] = 1'b1;
  end

  always_comb begin
    strobe.clearAll = invalidate;
    strobe.fillWr   = fillValid && !invalidate;
    strobe.fillWay  = (|fillMatch) ? fillMatch : victimOh;
    strobe.lkHit    = lookupValid && (|lkMatch) && !invalidate
                      && !(fillValid && sameSet);
    strobe.lkWay    = lkMatch;
  end

  // R5
  single_lk_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));
  // R5
  single_fill_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillMatch));
  // R6
  fill_free_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillWr && !(|fillMatch) && !(&fillValidRow))
      |-> ((strobe.fillWay & fillValidRow) == '0));
endmodule

// File: rtl/btic_top.sv
module btic_top
  import btic_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_W     = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               invalidate,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               fillValid,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [INSTR_W-1:0] fillInstr0,
  input  logic [INSTR_W-1:0] fillInstr1,
  output logic               hitValid,
  output logic [1:0]         hitCount,
  output logic [INSTR_W-1:0] hitInstr0,
  output logic [INSTR_W-1:0] hitInstr1
);
  localparam int IDX_W = $clog2(SETS);

  btStrobe_t strobe;
  wayVec_t   lkMatch, fillMatch, fillValidRow, fillPlru;
  logic      sameSet;

  btic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .invalidate(invalidate),
    .lookupValid(lookupValid), .fillValid(fillValid), .sameSet(sameSet),
    .lkMatch(lkMatch), .fillMatch(fillMatch), .fillValidRow(fillValidRow),
    .fillPlru(fillPlru), .strobe(strobe)
  );

  btic_dp #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .SETS(SETS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .fillAddr(fillAddr),
    .fillInstr0(fillInstr0), .fillInstr1(fillInstr1), .strobe(strobe),
    .lkMatch(lkMatch), .fillMatch(fillMatch), .fillValidRow(fillValidRow),
    .fillPlru(fillPlru), .sameSet(sameSet), .hitValid(hitValid),
    .hitCount(hitCount), .hitInstr0(hitInstr0), .hitInstr1(hitInstr1)
  );

  // R7
  set_conflict_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && fillValid
      && lookupAddr[2 +: IDX_W] == fillAddr[2 +: IDX_W]) |=> !hitValid);
  // R9
  inval_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> !hitValid);
  // R2
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !hitValid);
endmodule

// File: tb/btic_top_tb.sv
module btic_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invalidate = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic [31:0] fillInstr0 = '0;
  logic [31:0] fillInstr1 = '0;
  logic        hitValid;
  logic [1:0]  hitCount;
  logic [31:0] hitInstr0, hitInstr1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  btic_top u_dut (
    .clk(clk), .rstN(rstN), .invalidate(invalidate),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .fillInstr0(fillInstr0), .fillInstr1(fillInstr1),
    .hitValid(hitValid), .hitCount(hitCount),
    .hitInstr0(hitInstr0), .hitInstr1(hitInstr1)
  );

  function automatic logic [31:0] mkA(int tag, int set);
    return {tag[25:0], set[3:0], 2'b00};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outputs are read on the falling edge after the one rising edge
  task automatic expectOut(string req, logic h, int cnt, logic [31:0] w0, logic [31:0] w1);
    chk(req, "hitValid", {31'd0, hitValid}, {31'd0, h});
    chk(req, "hitCount", {30'd0, hitCount}, cnt);
    chk(req, "hitInstr0", hitInstr0, w0);
    chk(req, "hitInstr1", hitInstr1, w1);
  endtask

  task automatic doFill(logic [31:0] a, logic [31:0] w0, logic [31:0] w1);
    fillValid = 1'b1; fillAddr = a; fillInstr0 = w0; fillInstr1 = w1;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doLook(string req, logic [31:0] a, logic h, int cnt,
                        logic [31:0] w0, logic [31:0] w1);
    lookupValid = 1'b1; lookupAddr = a;
    @(negedge clk);
    lookupValid = 1'b0;
    expectOut(req, h, cnt, w0, w1);
  endtask

  task automatic tReset();
    expectOut("R1", 1'b0, 0, 32'h0, 32'h0);
    doLook("R1", mkA(5, 3), 1'b0, 0, 0, 0);
  endtask

  task automatic tBasic();
    doFill(mkA(5, 3), 32'hA0A0_0001, 32'hA0A0_0002);
    doLook("R2", mkA(5, 3), 1'b1, 2, 32'hA0A0_0001, 32'hA0A0_0002);
    doLook("R4", mkA(5, 3) | 32'h3, 1'b1, 2, 32'hA0A0_0001, 32'hA0A0_0002);
    doLook("R2", mkA(6, 3), 1'b0, 0, 0, 0);
    lookupAddr = mkA(5, 3);
    @(negedge clk);
    expectOut("R2", 1'b0, 0, 0, 0);
  endtask

  task automatic tLastWord();
    doFill(mkA(9, 7), 32'hB0B0_0001, 32'hB0B0_0002);
    doLook("R3", mkA(9, 7), 1'b1, 1, 32'hB0B0_0001, 32'h0);
    doFill(mkA(9, 15), 32'hB1B1_0001, 32'hB1B1_0002);
    doLook("R3", mkA(9, 15), 1'b1, 1, 32'hB1B1_0001, 32'h0);
    doFill(mkA(9, 14), 32'hB2B2_0001, 32'hB2B2_0002);
    doLook("R3", mkA(9, 14), 1'b1, 2, 32'hB2B2_0001, 32'hB2B2_0002);
  endtask

  task automatic tOverwrite();
    doFill(mkA(30, 11), 32'h3000, 32'h3001);
    doFill(mkA(31, 11), 32'h3100, 32'h3101);
    doFill(mkA(32, 11), 32'h3200, 32'h3201);
    doFill(mkA(33, 11), 32'h3300, 32'h3301);
    doFill(mkA(31, 11), 32'h31EE, 32'h31EF);
    doLook("R5", mkA(31, 11), 1'b1, 2, 32'h31EE, 32'h31EF);
    doLook("R5", mkA(30, 11), 1'b1, 2, 32'h3000, 32'h3001);
    doLook("R5", mkA(32, 11), 1'b1, 2, 32'h3200, 32'h3201);
    doLook("R5", mkA(33, 11), 1'b1, 2, 32'h3300, 32'h3301);
  endtask

  task automatic tReplace();
    for (int t = 20; t < 24; t++)
      doFill(mkA(t, 10), 32'h2000 + t, 32'h2100 + t);
    doLook("R6", mkA(20, 10), 1'b1, 2, 32'h2014, 32'h2114);
    doFill(mkA(24, 10), 32'h2018, 32'h2118);
    doLook("R6", mkA(22, 10), 1'b0, 0, 0, 0);
    doLook("R6", mkA(20, 10), 1'b1, 2, 32'h2014, 32'h2114);
    doLook("R6", mkA(21, 10), 1'b1, 2, 32'h2015, 32'h2115);
    doLook("R6", mkA(23, 10), 1'b1, 2, 32'h2017, 32'h2117);
    doLook("R6", mkA(24, 10), 1'b1, 2, 32'h2018, 32'h2118);
  endtask

  task automatic tConflict();
    fillValid = 1'b1; fillAddr = mkA(6, 3);
    fillInstr0 = 32'hC0C0_0001; fillInstr1 = 32'hC0C0_0002;
    doLook("R7", mkA(5, 3), 1'b0, 0, 0, 0);
    fillValid = 1'b0;
    doLook("R7", mkA(5, 3), 1'b1, 2, 32'hA0A0_0001, 32'hA0A0_0002);
    doLook("R7", mkA(6, 3), 1'b1, 2, 32'hC0C0_0001, 32'hC0C0_0002);
  endtask

  task automatic tParallel();
    fillValid = 1'b1; fillAddr = mkA(40, 12);
    fillInstr0 = 32'hD0D0_0001; fillInstr1 = 32'hD0D0_0002;
    doLook("R8", mkA(9, 7), 1'b1, 1, 32'hB0B0_0001, 32'h0);
    fillValid = 1'b0;
    doLook("R8", mkA(40, 12), 1'b1, 2, 32'hD0D0_0001, 32'hD0D0_0002);
  endtask

  task automatic tInvalidate();
    invalidate = 1'b1;
    fillValid = 1'b1; fillAddr = mkA(50, 1);
    fillInstr0 = 32'hE0; fillInstr1 = 32'hE1;
    doLook("R9", mkA(40, 12), 1'b0, 0, 0, 0);
    invalidate = 1'b0; fillValid = 1'b0;
    doLook("R9", mkA(40, 12), 1'b0, 0, 0, 0);
    doLook("R9", mkA(50, 1), 1'b0, 0, 0, 0);
    doLook("R9", mkA(5, 3), 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tLastWord();
    tOverwrite();
    tReplace();
    tConflict();
    tParallel();
    tInvalidate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule